// File: doc/BRIEF.md
# Isolated Bus Link Connection Sequencer

This block decides when the local two-wire bus drivers may follow the state of a remote bus that arrives over an isolation link. It tracks power-up, a hold-off window for the receiver, quiet detection on the local and the remote bus, a receive watchdog, and the disconnect and reconnect rules. Analog thresholds and the link codec are outside the block. It sees the local data and clock levels as raw, asynchronous inputs. It sees the remote levels as already-decoded synchronous inputs. Each good frame from the codec arrives as a one-cycle strobe.

The transmit side turns on as soon as the block is enabled and powered. The receive side turns on after a fixed hold-off. Bus drivers and rise accelerators turn on, and the active-low ready flag goes low, only when both buses are quiet in the same cycle. A bus is quiet after a STOP, or after a sustained idle with both lines high. The link drops when the receive watchdog expires, when a local stuck-bus event arrives, or when the peer reports a disconnect. After any drop, fresh quiet evidence is needed on both buses before the link comes back. All intervals are parameters in system clock cycles.

Top module: `link_conn_ctrl`

## Requirements
- R1: While `rst_ni` is low, or at any clock edge where `en_i` or `pwr_ok_i` is low, the block goes to its off state. In the off state `tx_en_o`, `rx_en_o`, `drv_en_o`, `acc_en_o` and `disc_req_o` are 0 and `ready_no` is 1. From the linked state, this takes effect at the first edge that samples the low input.
- R2: `tx_en_o` rises at the first edge that samples `en_i` and `pwr_ok_i` both high. `rx_en_o` stays low and then rises exactly HOLD_CYC+1 cycles after `tx_en_o` rose.
- R3: A bus becomes quiet after both of its lines have been high for IDLE_CYC consecutive cycles. For the local bus this count is taken after the SYNC_STAGES-flop synchronizer. The remote detector starts counting only once `rx_en_o` is high, so from `rx_en_o` rising with all lines idle, the link comes up exactly IDLE_CYC+1 cycles later.
- R4: A bus also becomes quiet at a STOP, defined as a data rise while clock is high. It stays quiet for as long as both lines remain high, with no idle count needed.
- R5: The link comes up one edge after a cycle in which the local and remote buses are both quiet, the receive watchdog has not expired, and neither `stuck_i` nor `peer_disc_i` is high. `drv_en_o` and `acc_en_o` rise and `ready_no` falls together. At all times `acc_en_o` equals `drv_en_o` and `ready_no` equals `!drv_en_o`.
- R6: While receiving is enabled, RXWD_CYC consecutive cycles without `rx_valid_i` expire the watchdog. A linked block then drops the link at the edge RXWD_CYC+1 cycles after the last strobe and pulses `disc_req_o` for one cycle. No reconnection happens until a new strobe arrives.
- R7: `stuck_i` high while linked drops the link at the next edge and pulses `disc_req_o` for one cycle.
- R8: `peer_disc_i` high while linked drops the link at the next edge, with `disc_req_o` left at 0.
- R9: A link drop discards all quiet evidence on both buses. Reconnection needs a new STOP or a new full idle interval on each bus.
- R10: Once linked, bus activity on either side (lines going low) does not drop the link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Block enable, synchronous |
| pwr_ok_i | input | 1 | Supply good and not over temperature, synchronous |
| loc_sda_i | input | 1 | Local data line level, asynchronous |
| loc_scl_i | input | 1 | Local clock line level, asynchronous |
| rem_sda_i | input | 1 | Remote data level decoded from the link |
| rem_scl_i | input | 1 | Remote clock level decoded from the link |
| rx_valid_i | input | 1 | One-cycle strobe per valid received frame |
| stuck_i | input | 1 | Local stuck-bus event |
| peer_disc_i | input | 1 | Disconnect message received from the peer |
| tx_en_o | output | 1 | Transmit side active |
| rx_en_o | output | 1 | Receive side active |
| drv_en_o | output | 1 | Local bus drivers follow the remote state |
| acc_en_o | output | 1 | Rise accelerators enabled |
| ready_no | output | 1 | Active-low linked flag |
| disc_req_o | output | 1 | One-cycle request to send a disconnect message |

## Verification
Every output decodes directly from the state register, so each result appears at the first edge after its cause. The exceptions are the three delays that are due at fixed counts. `rx_en_o` comes HOLD_CYC+1 edges after `tx_en_o`. An idle connect comes IDLE_CYC+1 edges after `rx_en_o`. A watchdog drop comes RXWD_CYC+1 edges after the last strobe. A local STOP needs two synchronizer edges, one edge to register the STOP and one to link. The bench drives inputs and samples outputs on falling edges. It measures each delay by counting falling edges until the output changes and compares the count to these figures. In the vector table, each row is held long enough that the expected value has settled before the row is checked.

// File: rtl/lcc_pkg.sv
package lcc_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_HOLD = 2'd1,
    ST_WAIT = 2'd2,
    ST_LINK = 2'd3
  } lcc_state_e;
endpackage

// File: rtl/lcc_sync.sv
module lcc_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] ff_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q[0] <= '1;
    else         ff_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[s] <= '1;
      else         ff_q[s] <= ff_q[s-1];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/lcc_timer.sv
module lcc_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (run_i && !done_o)    cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/lcc_quiet_det.sv
module lcc_quiet_det #(
  parameter int unsigned IDLE_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sda_i,
  input  logic scl_i,
  output logic quiet_o
);
  logic sda_q, stop_seen_q, idle_done;
  logic both_hi, stop_det, busy;

  assign both_hi  = sda_i & scl_i;
  assign stop_det = sda_i & ~sda_q & scl_i;
  assign busy     = clr_i | ~both_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q       <= 1'b1;
      stop_seen_q <= 1'b0;
    end else begin
      sda_q <= sda_i;
      if (busy)          stop_seen_q <= 1'b0;
      else if (stop_det) stop_seen_q <= 1'b1;
    end
  end

  lcc_timer #(.LIMIT(IDLE_CYC)) u_idle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (busy),
    .run_i  (1'b1),
    .done_o (idle_done)
  );

  assign quiet_o = stop_seen_q | idle_done;
endmodule

// File: rtl/link_conn_ctrl.sv
module link_conn_ctrl
  import lcc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 90000,
  parameter int unsigned IDLE_CYC    = 11500,
  parameter int unsigned RXWD_CYC    = 460000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pwr_ok_i,
  input  logic loc_sda_i,
  input  logic loc_scl_i,
  input  logic rem_sda_i,
  input  logic rem_scl_i,
  input  logic rx_valid_i,
  input  logic stuck_i,
  input  logic peer_disc_i,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic drv_en_o,
  output logic acc_en_o,
  output logic ready_no,
  output logic disc_req_o
);
  lcc_state_e state_q, state_d;
  logic [1:0] loc_sync;
  logic go_ok, rx_active, drop, link_ok;
  logic hold_done, rx_stale, loc_quiet, rem_quiet;
  logic disc_req_q;

  assign go_ok     = en_i & pwr_ok_i;
  assign rx_active = (state_q == ST_WAIT) || (state_q == ST_LINK);
  assign drop      = (state_q == ST_LINK) && go_ok && (rx_stale || stuck_i || peer_disc_i);
  assign link_ok   = loc_quiet && rem_quiet && !rx_stale && !stuck_i && !peer_disc_i;

  lcc_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({loc_sda_i, loc_scl_i}),
    .q_o    (loc_sync)
  );

  lcc_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q != ST_HOLD),
    .run_i  (1'b1),
    .done_o (hold_done)
  );

  // expiry holds until the next good frame
  lcc_timer #(.LIMIT(RXWD_CYC)) u_rxwd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!rx_active || rx_valid_i),
    .run_i  (1'b1),
    .done_o (rx_stale)
  );

  lcc_quiet_det #(.IDLE_CYC(IDLE_CYC)) u_loc_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   ((state_q == ST_OFF) || drop),
    .sda_i   (loc_sync[1]),
    .scl_i   (loc_sync[0]),
    .quiet_o (loc_quiet)
  );

  lcc_quiet_det #(.IDLE_CYC(IDLE_CYC)) u_rem_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (!rx_active || drop),
    .sda_i   (rem_sda_i),
    .scl_i   (rem_scl_i),
    .quiet_o (rem_quiet)
  );

  always_comb begin
    state_d = state_q;
    if (!go_ok) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_HOLD;
        ST_HOLD: if (hold_done) state_d = ST_WAIT;
        ST_WAIT: if (link_ok)   state_d = ST_LINK;
        ST_LINK: if (drop)      state_d = ST_WAIT;
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_OFF;
      disc_req_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      disc_req_q <= drop && (rx_stale || stuck_i);
    end
  end

  assign tx_en_o    = (state_q != ST_OFF);
  assign rx_en_o    = rx_active;
  assign drv_en_o   = (state_q == ST_LINK);
  assign acc_en_o   = (state_q == ST_LINK);
  assign ready_no   = (state_q != ST_LINK);
  assign disc_req_o = disc_req_q;
endmodule

// File: rtl/lcc_checker.sv
module lcc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic pwr_ok_i,
  input logic stuck_i,
  input logic peer_disc_i,
  input logic tx_en_o,
  input logic rx_en_o,
  input logic drv_en_o,
  input logic acc_en_o,
  input logic ready_no,
  input logic disc_req_o,
  input logic loc_quiet,
  input logic rem_quiet,
  input logic rx_stale
);
  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && pwr_ok_i) |=> (!tx_en_o && !rx_en_o && !drv_en_o && ready_no && !disc_req_o)); // R1

  AST_TX_NEEDS_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(en_i && pwr_ok_i)); // R2

  AST_RX_NEEDS_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en_o |-> tx_en_o); // R2

  AST_RX_AFTER_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_en_o) |-> $past(tx_en_o)); // R2

  AST_LINK_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_en_o == drv_en_o) && (ready_no == !drv_en_o)); // R5

  AST_DRV_NEEDS_RX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> rx_en_o); // R5

  AST_CONNECT_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drv_en_o) |-> $past(loc_quiet && rem_quiet && !rx_stale)); // R5

  AST_DREQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disc_req_o |=> !disc_req_o); // R6

  AST_STUCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuck_i && drv_en_o && en_i && pwr_ok_i) |=> (!drv_en_o && disc_req_o)); // R7

  AST_PEER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (peer_disc_i && drv_en_o) |=> !drv_en_o); // R8
endmodule

bind link_conn_ctrl lcc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .pwr_ok_i    (pwr_ok_i),
  .stuck_i     (stuck_i),
  .peer_disc_i (peer_disc_i),
  .tx_en_o     (tx_en_o),
  .rx_en_o     (rx_en_o),
  .drv_en_o    (drv_en_o),
  .acc_en_o    (acc_en_o),
  .ready_no    (ready_no),
  .disc_req_o  (disc_req_o),
  .loc_quiet   (loc_quiet),
  .rem_quiet   (rem_quiet),
  .rx_stale    (rx_stale)
);

// File: tb/sim_link_conn_ctrl.sv
module sim_link_conn_ctrl;
  localparam int HOLD = 20;
  localparam int IDLE = 10;
  localparam int WD   = 40;
  localparam int NV   = 13;

  // {lsda, lscl, rsda, rscl, peer_disc, exp_drv, cycles[6:0]}
  localparam logic [12:0] VEC [NV] = '{
    {6'b11111_0, 7'd1},   // peer drop from link            R8
    {6'b11110_0, 7'd3},   // idle too short                 R9
    {6'b11110_1, 7'd12},  // both idle                      R3
    {6'b01110_1, 7'd4},   // local activity while linked    R10
    {6'b01111_0, 7'd1},   // peer drop
    {6'b01110_0, 7'd15},  // local data low
    {6'b00110_0, 7'd3},   // local clock low
    {6'b01110_0, 7'd3},   // clock up, data low
    {6'b11110_1, 7'd5},   // local STOP                     R4
    {6'b11111_0, 7'd1},   // peer drop
    {6'b11010_0, 7'd3},   // remote data low
    {6'b11110_0, 7'd3},   // remote STOP, local idle short  R5
    {6'b11110_1, 7'd8}    // local idle completes           R5
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, en, pwr_ok, lsda, lscl, rsda, rscl, stuck, peer;
  logic feed, man_valid, rx_valid;
  logic tx_en, rx_en, drv_en, acc_en, ready_n, disc_req;
  logic [1:0] fcnt = 2'd0;
  int total = 0, bad = 0;
  bit fin = 1'b0;

  always @(negedge clk) fcnt <= fcnt + 2'd1;
  assign rx_valid = (feed && fcnt == 2'd0) || man_valid;

  link_conn_ctrl #(.SYNC_STAGES(2), .HOLD_CYC(HOLD), .IDLE_CYC(IDLE), .RXWD_CYC(WD)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pwr_ok_i(pwr_ok),
    .loc_sda_i(lsda), .loc_scl_i(lscl), .rem_sda_i(rsda), .rem_scl_i(rscl),
    .rx_valid_i(rx_valid), .stuck_i(stuck), .peer_disc_i(peer),
    .tx_en_o(tx_en), .rx_en_o(rx_en), .drv_en_o(drv_en), .acc_en_o(acc_en),
    .ready_no(ready_n), .disc_req_o(disc_req)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_link(string tag, bit exp);
    chk({tag, " drv_en"}, int'(drv_en), int'(exp));
    chk({tag, " acc_en"}, int'(acc_en), int'(exp));
    chk({tag, " ready_n"}, int'(ready_n), int'(!exp));
  endtask

  task automatic chk_off(string tag);
    chk({tag, " tx_en"}, int'(tx_en), 0);
    chk({tag, " rx_en"}, int'(rx_en), 0);
    chk({tag, " disc_req"}, int'(disc_req), 0);
    chk_link(tag, 1'b0);
  endtask

  task automatic bring_up(string tag);
    int k;
    @(negedge clk);
    chk({tag, " R2 tx_en"}, int'(tx_en), 1);
    chk({tag, " R2 rx_en held"}, int'(rx_en), 0);
    k = 0;
    while (!rx_en && k < 1000) begin @(negedge clk); k++; end
    chk({tag, " R2 rx delay"}, k, HOLD + 1);
    k = 0;
    while (!drv_en && k < 1000) begin @(negedge clk); k++; end
    chk({tag, " R3 idle link delay"}, k, IDLE + 1);
    chk_link({tag, " R5 linked"}, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int k;
    rst_n = 1'b0; en = 1'b0; pwr_ok = 1'b1;
    lsda = 1'b1; lscl = 1'b1; rsda = 1'b1; rscl = 1'b1;
    stuck = 1'b0; peer = 1'b0; feed = 1'b1; man_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk_off("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_off("R1 enable low");
    en = 1'b1;
    bring_up("startup");

    for (int i = 0; i < NV; i++) begin
      {lsda, lscl, rsda, rscl, peer} = VEC[i][12:8];
      repeat (int'(VEC[i][6:0])) @(negedge clk);
      peer = 1'b0;
      chk($sformatf("table row %0d R3 R4 R5 R9 R10 drv_en", i), int'(drv_en), int'(VEC[i][7]));
    end
    {lsda, lscl, rsda, rscl} = 4'b1111;

    // peer disconnect: no request, old quiet discarded
    peer = 1'b1; @(negedge clk); peer = 1'b0;
    chk_link("R8 peer drop", 1'b0);
    chk("R8 no disc_req", int'(disc_req), 0);
    repeat (3) @(negedge clk);
    chk_link("R9 fresh quiet needed", 1'b0);
    repeat (12) @(negedge clk);
    chk_link("R9 relinked", 1'b1);

    // local stuck
    stuck = 1'b1; @(negedge clk); stuck = 1'b0;
    chk_link("R7 stuck drop", 1'b0);
    chk("R7 disc_req pulse", int'(disc_req), 1);
    @(negedge clk);
    chk("R7 disc_req single", int'(disc_req), 0);
    repeat (15) @(negedge clk);
    chk_link("R7 relinked", 1'b1);

    // receive watchdog
    feed = 1'b0; man_valid = 1'b1; @(negedge clk); man_valid = 1'b0;
    k = 0;
    while (drv_en && k < 1000) begin @(negedge clk); k++; end
    chk("R6 watchdog delay", k, WD + 1);
    chk("R6 disc_req pulse", int'(disc_req), 1);
    repeat (3 * IDLE) @(negedge clk);
    chk_link("R6 stale blocks link", 1'b0);
    feed = 1'b1;
    repeat (8) @(negedge clk);
    chk_link("R6 relink after frame", 1'b1);

    // power loss from link, then full sequence
    pwr_ok = 1'b0; @(negedge clk);
    chk_off("R1 power loss");
    pwr_ok = 1'b1;
    bring_up("repower");

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule